// File: doc/BRIEF.md
# Key-Tuned Sine Synthesizer

This block is a direct digital synthesizer that drives an external current-output DAC for an eddy-current excitation source. A 20-bit phase accumulator advances by a tuning word on every system clock. The top ten accumulator bits, plus a ten-bit phase offset, form a registered address into a 1024-entry sine table. The table sample is presented to the DAC together with a DAC clock at half the system rate. At 50 MHz one tuning step is 50e6 / 2^20, about 47.68 Hz, so the range of 1 to 1024 steps covers roughly 47.7 Hz to 48.8 kHz. The default word of 105 gives about 5 kHz.

Three push buttons tune the output. The up and down keys move the tuning word by one step. The phase key advances the offset by a quarter turn. Each button is synchronised and debounced, and one press acts exactly once. A phase step also clears the accumulator and the address register. The waveform therefore restarts cleanly from the new offset, and the phase the accumulator had built up at the old frequency is lost.

Top module: `dds_keyed_synth`

## Requirements
- R1: On each clock edge without a phase step, the accumulator takes its previous value plus the tuning word, modulo 2^20.
- R2: On each clock edge without a phase step, the table address register loads accumulator bits 19..10 plus the phase offset, modulo 1024.
- R3: Table entry k holds floor(512 + 511*sin(2*pi*k/1024) + 0.5), an offset-binary code centred on 512.
- R4: A debounced up press raises the tuning word by one, saturating at 1024. A down press lowers it by one, saturating at 1. Neither wraps, and up wins if both act in the same cycle.
- R5: A phase press adds 256 (a quarter turn) to the phase offset, modulo 1024, so four presses return the offset to 0.
- R6: dac_clk starts at 0 after reset and toggles on every system clock edge.
- R7: dac_data changes only on edges where dac_clk falls. It then loads the table entry at the current address register, so it is stable at each rising edge of dac_clk.
- R8: On the edge that applies a phase step, the accumulator and the address register both become 0. On the next edge the address becomes the new offset and the accumulator becomes the tuning word.
- R9: While rst_n is low at a clock edge (synchronous reset), the block sets: accumulator 0, address 0, offset 0, tuning word 105, dac_clk 0, dac_data 512.
- R10: A key level that stays high for fewer than DEBOUNCE_CYC consecutive synchronised samples has no effect. A longer hold acts once, no matter how long it lasts.
- R11: A key sampled high at edge E0 and then held acts on edge E0 + DEBOUNCE_CYC + 2. This covers the two synchroniser stages, the debounce count and one pulse register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| key_up | input | 1 | Raise-frequency button, high when pressed |
| key_down | input | 1 | Lower-frequency button, high when pressed |
| key_phase | input | 1 | Quarter-turn phase button, high when pressed |
| dac_clk | output | 1 | DAC sample clock, system clock divided by two |
| dac_data | output | 10 | Offset-binary sample for the DAC |

## Verification
The bench builds the block with DEBOUNCE_CYC = 8 in place of the 20 ms default and keeps every other width and the 105 reset word. The short debounce window lets one press complete in under 30 cycles. This puts both saturation limits within reach: about 900 presses up to 1024 and about 1000 down to 1. It also allows sub-threshold glitches, long holds and the four-press phase wrap to be driven against a cycle-exact reference of the sample stream.

// File: rtl/dds_pkg.sv
// Shared definitions for the key-tuned sine synthesizer.
// Assumes three buttons in a fixed order inside the key vector.
package dds_pkg;
    localparam int NUM_KEYS = 3;

    typedef enum logic [1:0] {
        KEY_UP    = 2'd0,
        KEY_DOWN  = 2'd1,
        KEY_PHASE = 2'd2
    } key_idx_e;
endpackage

// File: rtl/dds_key_filter.sv
// Two-flop synchroniser plus stable-level debounce for one button.
// Emits a one-clock pulse when a new high level has held for
// DEBOUNCE_CYC consecutive samples. Release is filtered the same way
// and emits nothing. Assumes DEBOUNCE_CYC >= 2.
module dds_key_filter #(
    parameter int DEBOUNCE_CYC = 1_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic key_raw,
    output logic press_pulse
);
    localparam int CNT_W = $clog2(DEBOUNCE_CYC);

    logic             sync_a, sync_b, level_q;
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == CNT_W'(DEBOUNCE_CYC - 1));

    // Synchronise the raw level, count its disagreement with the accepted level, pulse on an accepted rise
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_a      <= 1'b0;
            sync_b      <= 1'b0;
            level_q     <= 1'b0;
            cnt_q       <= '0;
            press_pulse <= 1'b0;
        end else begin
            sync_a      <= key_raw;
            sync_b      <= sync_a;
            press_pulse <= (sync_b != level_q) && at_limit && sync_b;
            if (sync_b == level_q) begin
                cnt_q <= '0;
            end else if (at_limit) begin
                level_q <= sync_b;
                cnt_q   <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/dds_tuning_ctrl.sv
// Holds the frequency tuning word and the phase offset.
// Up/down pulses step the word within [1, 2^ADDR_W] with no wrap, and
// up wins a tie. A phase pulse adds a quarter turn modulo the table depth.
module dds_tuning_ctrl #(
    parameter int ADDR_W   = 10,
    parameter int FTW_W    = 11,
    parameter int FTW_INIT = 105
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              up_pulse,
    input  logic              down_pulse,
    input  logic              phase_pulse,
    output logic [FTW_W-1:0]  ftw,
    output logic [ADDR_W-1:0] phase_off
);
    localparam int FTW_MAX    = 1 << ADDR_W;
    localparam int PHASE_STEP = 1 << (ADDR_W - 2);

    // Saturating tuning-word steps and wrapping quarter-turn offset steps
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ftw       <= FTW_W'(FTW_INIT);
            phase_off <= '0;
        end else begin
            if (up_pulse) begin
                if (ftw != FTW_W'(FTW_MAX)) ftw <= ftw + 1'b1;
            end else if (down_pulse) begin
                if (ftw != FTW_W'(1)) ftw <= ftw - 1'b1;
            end
            if (phase_pulse) phase_off <= phase_off + ADDR_W'(PHASE_STEP);
        end
    end
endmodule

// File: rtl/dds_phase_core.sv
// Phase accumulator and registered table address.
// A clear request zeroes both registers. The new offset then enters
// the address on the following edge.
module dds_phase_core #(
    parameter int ACC_W  = 20,
    parameter int ADDR_W = 10,
    parameter int FTW_W  = 11
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [FTW_W-1:0]  ftw,
    input  logic [ADDR_W-1:0] phase_off,
    output logic [ACC_W-1:0]  acc,
    output logic [ADDR_W-1:0] addr
);
    // Accumulate the tuning word and form the offset table address
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc  <= '0;
            addr <= '0;
        end else begin
            acc  <= acc + ACC_W'(ftw);
            addr <= acc[ACC_W-1 -: ADDR_W] + phase_off;
        end
    end
endmodule

// File: rtl/dds_dac_stage.sv
// Sine table computed at elaboration, plus the DAC output register.
// The DAC clock is the system clock halved. A sample loads only on the
// edge where that clock falls, so it is stable at the DAC's rising edge.
module dds_dac_stage #(
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              dac_clk,
    output logic [AMP_W-1:0]  dac_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int MID   = 1 << (AMP_W - 1);

    logic [AMP_W-1:0] wave_tab [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_tab
        localparam real ANG = 6.283185307179586 * real'(i) / real'(DEPTH);
        localparam int  VAL = $rtoi(real'(MID) + real'(MID - 1) * $sin(ANG) + 0.5);
        assign wave_tab[i] = AMP_W'(VAL);
    end

    // Halve the clock and load a new sample on its falling edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dac_clk  <= 1'b0;
            dac_data <= AMP_W'(MID);
        end else begin
            dac_clk <= ~dac_clk;
            if (dac_clk) dac_data <= wave_tab[addr];
        end
    end
endmodule

// File: rtl/dds_keyed_synth.sv
// Top of the key-tuned sine synthesizer: three debounced buttons, tuning
// registers, the phase core and the DAC output stage.
// Assumes buttons are high when pressed and that reset is synchronous.
module dds_keyed_synth
    import dds_pkg::*;
#(
    parameter int ACC_W        = 20,
    parameter int ADDR_W       = 10,
    parameter int AMP_W        = 10,
    parameter int FTW_INIT     = 105,
    parameter int DEBOUNCE_CYC = 1_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             key_up,
    input  logic             key_down,
    input  logic             key_phase,
    output logic             dac_clk,
    output logic [AMP_W-1:0] dac_data
);
    localparam int FTW_W = ADDR_W + 1;

    logic [NUM_KEYS-1:0] keys, pulses;
    logic [FTW_W-1:0]    ftw;
    logic [ADDR_W-1:0]   phase_off, addr;
    logic [ACC_W-1:0]    acc;

    assign keys[KEY_UP]    = key_up;
    assign keys[KEY_DOWN]  = key_down;
    assign keys[KEY_PHASE] = key_phase;

    for (genvar k = 0; k < NUM_KEYS; k++) begin : g_key
        dds_key_filter #(.DEBOUNCE_CYC(DEBOUNCE_CYC)) u_filt (
            .clk        (clk),
            .rst_n      (rst_n),
            .key_raw    (keys[k]),
            .press_pulse(pulses[k])
        );
    end

    dds_tuning_ctrl #(.ADDR_W(ADDR_W), .FTW_W(FTW_W), .FTW_INIT(FTW_INIT)) u_tune (
        .clk        (clk),
        .rst_n      (rst_n),
        .up_pulse   (pulses[KEY_UP]),
        .down_pulse (pulses[KEY_DOWN]),
        .phase_pulse(pulses[KEY_PHASE]),
        .ftw        (ftw),
        .phase_off  (phase_off)
    );

    dds_phase_core #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .FTW_W(FTW_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (pulses[KEY_PHASE]),
        .ftw      (ftw),
        .phase_off(phase_off),
        .acc      (acc),
        .addr     (addr)
    );

    dds_dac_stage #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_dac (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .dac_clk (dac_clk),
        .dac_data(dac_data)
    );
endmodule

// File: rtl/dds_keyed_synth_chk.sv
// Property checker for the key-tuned sine synthesizer, bound to its top.
module dds_keyed_synth_chk #(
    parameter int ACC_W  = 20,
    parameter int ADDR_W = 10,
    parameter int AMP_W  = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              dac_clk,
    input logic [AMP_W-1:0]  dac_data,
    input logic [ADDR_W:0]   ftw,
    input logic [ADDR_W-1:0] phase_off,
    input logic [ACC_W-1:0]  acc,
    input logic [ADDR_W-1:0] addr,
    input logic [2:0]        pulses
);
    localparam int FTW_MAX    = 1 << ADDR_W;
    localparam int PHASE_STEP = 1 << (ADDR_W - 2);

    a_r1_acc_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !pulses[2] |=> acc == $past(acc) + ACC_W'($past(ftw)));

    a_r2_addr_offset: assert property (@(posedge clk) disable iff (!rst_n)
        !pulses[2] |=> addr == $past(acc[ACC_W-1 -: ADDR_W]) + $past(phase_off));

    a_r4_ftw_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        (ftw >= (ADDR_W+1)'(1)) && (ftw <= (ADDR_W+1)'(FTW_MAX)));

    a_r4_ftw_unit_step: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (ftw == $past(ftw)) || (ftw == $past(ftw) + 1'b1) || (ftw + 1'b1 == $past(ftw)));

    a_r5_quarter_turn: assert property (@(posedge clk) disable iff (!rst_n)
        pulses[2] |=> phase_off == $past(phase_off) + ADDR_W'(PHASE_STEP));

    a_r6_dac_clk_toggle: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> dac_clk != $past(dac_clk));

    a_r7_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !dac_clk |=> $stable(dac_data));

    a_r8_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
        pulses[2] |=> (acc == '0) && (addr == '0));

    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (pulses != 3'b000) |=> (pulses & $past(pulses)) == 3'b000);
endmodule

bind dds_keyed_synth dds_keyed_synth_chk #(
    .ACC_W (ACC_W),
    .ADDR_W(ADDR_W),
    .AMP_W (AMP_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .dac_clk  (dac_clk),
    .dac_data (dac_data),
    .ftw      (ftw),
    .phase_off(phase_off),
    .acc      (acc),
    .addr     (addr),
    .pulses   (pulses)
);

// File: tb/dds_keyed_synth_test.sv
`timescale 1ns/1ps
// Directed bench: a cycle-exact reference of the sample stream is
// compared at every falling clock edge, and each scenario task checks
// that no mismatch appeared while it ran.
module dds_keyed_synth_test;
    localparam int DEB = 8;

    logic       clk = 1'b0, rst_n = 1'b0;
    logic       key_up = 1'b0, key_down = 1'b0, key_phase = 1'b0;
    logic       dac_clk;
    logic [9:0] dac_data;

    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    dds_keyed_synth #(.DEBOUNCE_CYC(DEB)) uut (
        .clk(clk), .rst_n(rst_n), .key_up(key_up), .key_down(key_down),
        .key_phase(key_phase), .dac_clk(dac_clk), .dac_data(dac_data)
    );

    // Reference model built from R1..R9
    logic [9:0]  m_tab [1024];
    logic [19:0] m_acc;
    logic [9:0]  m_addr, m_off, m_data;
    int          m_ftw;
    logic        m_dclk;
    bit          req_up = 0, req_down = 0, req_ph = 0;
    bit          mon_en = 0;
    int          mm = 0;
    logic [10:0] mm_act, mm_exp;

    initial begin
        for (int i = 0; i < 1024; i++)
            m_tab[i] = 10'($rtoi(512.0 + 511.0 * $sin(6.283185307179586 * real'(i) / 1024.0) + 0.5));
    end

    always @(posedge clk) begin
        if (!rst_n) begin
            m_acc <= '0; m_addr <= '0; m_off <= '0; m_ftw <= 105;
            m_dclk <= 1'b0; m_data <= 10'd512;
        end else begin
            m_dclk <= ~m_dclk;
            if (m_dclk) m_data <= m_tab[m_addr];
            if (req_ph) begin
                m_acc <= '0; m_addr <= '0; m_off <= m_off + 10'd256;
            end else begin
                m_acc  <= m_acc + 20'(m_ftw);
                m_addr <= m_acc[19:10] + m_off;
            end
            if (req_up) begin
                if (m_ftw < 1024) m_ftw <= m_ftw + 1;
            end else if (req_down) begin
                if (m_ftw > 1) m_ftw <= m_ftw - 1;
            end
        end
    end

    always @(negedge clk) begin
        if (mon_en && ({dac_clk, dac_data} !== {m_dclk, m_data})) begin
            mm     <= mm + 1;
            mm_act <= {dac_clk, dac_data};
            mm_exp <= {m_dclk, m_data};
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Observe n cycles and check that the stream matched the reference throughout
    task automatic window(input int n, input string req);
        int base = mm;
        repeat (n) @(negedge clk);
        check(mm == base, req, int'(mm_act), int'(mm_exp));
    endtask

    // Press key 0=up 1=down 2=phase; the effect lands on edge E0+DEB+2 (R11)
    task automatic press(input int which, input int hold);
        @(negedge clk);
        case (which)
            0: key_up = 1'b1;
            1: key_down = 1'b1;
            default: key_phase = 1'b1;
        endcase
        repeat (DEB + 2) @(negedge clk);
        case (which)
            0: req_up = 1;
            1: req_down = 1;
            default: req_ph = 1;
        endcase
        @(negedge clk);
        req_up = 0; req_down = 0; req_ph = 0;
        repeat (hold) @(negedge clk);
        key_up = 1'b0; key_down = 1'b0; key_phase = 1'b0;
        repeat (DEB + 6) @(negedge clk);
    endtask

    task automatic t_reset_state;   // R9
        check(dac_data == 10'd512, "R9 reset data", int'(dac_data), 512);
        check(dac_clk == 1'b0, "R9 reset dac_clk", int'(dac_clk), 0);
    endtask

    task automatic t_free_run;      // R1 R2 R3 R7 at the 5 kHz default
        window(3000, "R3 free-run sine stream");
    endtask

    task automatic t_dac_clock;     // R6
        logic prev = dac_clk;
        bit   ok = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dac_clk == prev) ok = 1'b0;
            prev = dac_clk;
        end
        check(ok, "R6 dac_clk toggles", int'(dac_clk), int'(~prev));
    endtask

    task automatic t_freq_steps;    // R4 R11
        for (int i = 0; i < 3; i++) press(0, 2);
        window(1500, "R4 three up steps");
        for (int i = 0; i < 5; i++) press(1, 2);
        window(1500, "R4 five down steps");
    endtask

    task automatic t_phase_step;    // R5 R8
        press(2, 2);
        window(1500, "R8 phase step clears and restarts");
        for (int i = 0; i < 3; i++) press(2, 2);
        window(1500, "R5 four quarter turns wrap to zero");
    endtask

    task automatic t_glitch_and_hold;   // R10
        @(negedge clk);
        key_up = 1'b1;
        repeat (DEB - 2) @(negedge clk);
        key_up = 1'b0;
        window(600, "R10 short glitch ignored");
        press(1, 5 * DEB);
        window(600, "R10 long hold acts once");
    endtask

    task automatic t_saturate_up;   // R4 upper limit
        for (int i = 0; i < 925; i++) press(0, 1);
        window(1500, "R4 saturate at 1024");
    endtask

    task automatic t_saturate_down; // R4 lower limit
        for (int i = 0; i < 1026; i++) press(1, 1);
        window(2500, "R4 saturate at 1");
    endtask

    task automatic t_mid_reset;     // R9 synchronous reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        t_reset_state();
        rst_n = 1'b1;
        window(800, "R9 restart after reset");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        t_reset_state();
        mon_en = 1;
        rst_n  = 1'b1;
        t_free_run();
        t_dac_clock();
        t_freq_steps();
        t_phase_step();
        t_glitch_and_hold();
        t_saturate_up();
        t_saturate_down();
        t_mid_reset();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule